// File: doc/BRIEF.md
# Pipelined Request Queue Capture

This block sits on the target side of a graphics bus. It collects requests that a bus master sends back to back without a handshake for each one. The master holds an active-low pipe strobe low. On every rising clock edge while the strobe is low, the block takes one full 32-bit address from the address/data bus. On the same edge it takes one 4-bit command code from the command lines. In this mode those lines carry a request command, not byte enables. Each request is decoded into a direction and a priority and stored in order in a request FIFO. A downstream scheduler drains the FIFO through a valid/ready pop port.

Capture needs permission from the arbiter. The arbiter gives it by driving its active-low grant together with the start-transaction status code. Strobe activity without that permission is thrown away and raises a sticky protocol-error flag. A request that finds the queue full is also dropped, and it raises a sticky overflow flag. A master that never uses the pipe strobe leaves the block idle.

Top module: `req_queue_capture`

## Requirements
- R1: After reset the pop port shows no valid entry and both error flags are low.
- R2: While the pipe strobe is low and capture is permitted, exactly one request (address plus command) is queued on each rising clock edge.
- R3: On an edge where the pipe strobe is high, nothing is queued.
- R4: Permission is opened by an edge on which the grant is low and the status is 3'b111. That edge itself may capture. Permission then persists across idle edges until a burst ends: the first edge with the strobe high that follows an edge that captured. After that a new start grant is needed. Grant low with any other status code, or status 3'b111 with grant high, gives no permission.
- R5: An edge with the strobe low and no permission queues nothing and sets the protocol-error flag, which stays set until reset.
- R6: Command bit 0 set marks a write (clear marks a read). Command bit 1 set marks high priority (clear marks low). Each entry presents its address, its raw 4-bit command and both decoded bits.
- R7: Entries leave in arrival order. An entry is popped on an edge with valid and ready both high. While it is not popped, the head entry stays stable.
- R8: With DEPTH entries held and no pop on that edge, a capture is dropped, the contents are unchanged, and the overflow flag sets and stays set until reset.
- R9: With the queue full and a pop on the same edge, a capture is accepted.
- R10: With the strobe never asserted, no entry is ever queued and no error flag rises, whatever the grant and status do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_pipe_n | input | 1 | Active-low pipe strobe from the master |
| arb_gnt_n | input | 1 | Active-low grant from the arbiter |
| arb_status | input | 3 | Arbiter status code, 3'b111 = start transaction |
| bus_ad | input | 32 | Address/data bus |
| bus_cmd | input | 4 | Command lines carrying the request command |
| q_ready | input | 1 | Scheduler ready to take the head entry |
| q_valid | output | 1 | Head entry valid |
| q_addr | output | 32 | Head entry address |
| q_cmd | output | 4 | Head entry raw command |
| q_is_write | output | 1 | Head entry direction, 1 = write |
| q_high_pri | output | 1 | Head entry priority, 1 = high |
| overflow_err | output | 1 | Sticky flag: request dropped because the queue was full |
| protocol_err | output | 1 | Sticky flag: strobe seen without permission |

## Verification
A wrong pointer or count shows up on the pop port within one cycle of the edge that corrupts it. It appears as a wrong head entry, out-of-order data, a valid that drops too soon, or a valid that stays high after the last entry. A wrong permission state appears one cycle later, either as an entry that should not exist or as a protocol-error flag that rises when it should not. The full boundary is checked by how many entries drain after a fill and by the overflow flag.

// File: rtl/rqc_pkg.sv
package rqc_pkg;
    localparam int ADDR_W = 32;
    localparam int CMD_W  = 4;
    localparam logic [2:0] ST_START = 3'b111;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CMD_W-1:0]  cmd;
        logic              is_write;
        logic              high_pri;
    } req_entry_t;

    function automatic req_entry_t make_entry(logic [ADDR_W-1:0] a, logic [CMD_W-1:0] c);
        req_entry_t e;
        e.addr     = a;
        e.cmd      = c;
        e.is_write = c[0];
        e.high_pri = c[1];
        return e;
    endfunction
endpackage

// File: rtl/rqc_grant_qual.sv
module rqc_grant_qual
    import rqc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pipe_n,
    input  logic       gnt_n,
    input  logic [2:0] status,
    output logic       capture,
    output logic       protocol_err
);
    typedef struct packed {
        logic armed;
        logic burst;
        logic perr;
    } gq_state_t;

    gq_state_t gq_d, gq_q;
    logic start_now, permit, pipe_on;

    always_comb begin
        pipe_on   = !pipe_n;
        start_now = !gnt_n && (status == ST_START);
        permit    = gq_q.armed || start_now;
        capture   = pipe_on && permit;
        gq_d       = gq_q;
        gq_d.armed = start_now || (gq_q.armed && (pipe_on || !gq_q.burst));
        gq_d.burst = capture;
        if (pipe_on && !permit) gq_d.perr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gq_q <= '0;
        else        gq_q <= gq_d;
    end

    assign protocol_err = gq_q.perr;

    // R5
    perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        protocol_err |=> protocol_err);
    // R5
    perr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(protocol_err) |-> $past(!pipe_n));
endmodule

// File: rtl/rqc_fifo.sv
module rqc_fifo
    import rqc_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_req,
    input  req_entry_t in_entry,
    input  logic       pop_ready,
    output logic       out_valid,
    output req_entry_t out_entry,
    output logic       overflow
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

    typedef struct {
        req_entry_t     slot [DEPTH];
        logic [PW-1:0]  rd;
        logic [PW-1:0]  wr;
        logic [CW-1:0]  cnt;
        logic           ovf;
    } fifo_state_t;

    fifo_state_t f_d, f_q;
    logic pop, accept;

    always_comb begin
        pop    = (f_q.cnt != '0) && pop_ready;
        accept = push_req && ((f_q.cnt != FULL_CNT) || pop);
        f_d    = f_q;
        if (pop) f_d.rd = (f_q.rd == LAST_IDX) ? '0 : f_q.rd + 1'b1;
        if (accept) begin
            f_d.slot[f_q.wr] = in_entry;
            f_d.wr = (f_q.wr == LAST_IDX) ? '0 : f_q.wr + 1'b1;
        end
        f_d.cnt = f_q.cnt + CW'(accept) - CW'(pop);
        if (push_req && !accept) f_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.rd  <= '0;
            f_q.wr  <= '0;
            f_q.cnt <= '0;
            f_q.ovf <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    assign out_valid = (f_q.cnt != '0);
    assign out_entry = f_q.slot[f_q.rd];
    assign overflow  = f_q.ovf;

    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.cnt <= FULL_CNT);
    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    // R8
    drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && (f_q.cnt == FULL_CNT) && !pop_ready) |=> $stable(f_q.cnt));
    // R7
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !pop_ready) |=> (out_valid && $stable(out_entry)));
endmodule

// File: rtl/req_queue_capture.sv
module req_queue_capture
    import rqc_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_pipe_n,
    input  logic        arb_gnt_n,
    input  logic [2:0]  arb_status,
    input  logic [31:0] bus_ad,
    input  logic [3:0]  bus_cmd,
    input  logic        q_ready,
    output logic        q_valid,
    output logic [31:0] q_addr,
    output logic [3:0]  q_cmd,
    output logic        q_is_write,
    output logic        q_high_pri,
    output logic        overflow_err,
    output logic        protocol_err
);
    logic       capture;
    req_entry_t new_entry, head;

    rqc_grant_qual u_qual (
        .clk          (clk),
        .rst_n        (rst_n),
        .pipe_n       (req_pipe_n),
        .gnt_n        (arb_gnt_n),
        .status       (arb_status),
        .capture      (capture),
        .protocol_err (protocol_err)
    );

    assign new_entry = make_entry(bus_ad, bus_cmd);

    rqc_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (capture),
        .in_entry  (new_entry),
        .pop_ready (q_ready),
        .out_valid (q_valid),
        .out_entry (head),
        .overflow  (overflow_err)
    );

    assign q_addr     = head.addr;
    assign q_cmd      = head.cmd;
    assign q_is_write = head.is_write;
    assign q_high_pri = head.high_pri;

    // R3
    idle_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_pipe_n && !q_valid) |=> !q_valid);
endmodule

// File: tb/req_queue_capture_tb.sv
module req_queue_capture_tb_top;
    localparam int D = 4;
    logic clk = 0, rst_n = 0;
    logic pipe_n = 1, gnt_n = 1, q_ready = 0;
    logic [2:0] st = 0;
    logic [31:0] ad = 0;
    logic [3:0] cmd = 0;
    logic q_valid, q_is_write, q_high_pri, overflow_err, protocol_err;
    logic [31:0] q_addr;
    logic [3:0] q_cmd;

    int checks = 0, errors = 0;
    logic [35:0] model [$];
    logic m_armed, m_burst, m_ovf, m_perr;

    always #10 clk = ~clk;

    req_queue_capture #(.DEPTH(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_pipe_n(pipe_n), .arb_gnt_n(gnt_n),
        .arb_status(st), .bus_ad(ad), .bus_cmd(cmd), .q_ready(q_ready),
        .q_valid(q_valid), .q_addr(q_addr), .q_cmd(q_cmd), .q_is_write(q_is_write),
        .q_high_pri(q_high_pri), .overflow_err(overflow_err), .protocol_err(protocol_err));

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_ports(input string tag);
        logic ev;
        ev = (model.size() != 0);
        chk(q_valid == ev, tag, "valid", q_valid, ev);
        if (ev) begin
            chk(q_addr == model[0][35:4], tag, "addr", q_addr, model[0][35:4]);
            chk(q_cmd == model[0][3:0], tag, "cmd", q_cmd, model[0][3:0]);
            chk(q_is_write == model[0][0], tag, "write", q_is_write, model[0][0]);
            chk(q_high_pri == model[0][1], tag, "hipri", q_high_pri, model[0][1]);
        end
        chk(overflow_err == m_ovf, tag, "overflow", overflow_err, m_ovf);
        chk(protocol_err == m_perr, tag, "protocol", protocol_err, m_perr);
    endtask

    task automatic do_reset();
        rst_n = 0; pipe_n = 1; gnt_n = 1; st = 0; q_ready = 0;
        model.delete();
        m_armed = 0; m_burst = 0; m_ovf = 0; m_perr = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    // one edge: drive at negedge, predict, check at following negedge
    task automatic step(input bit p, input bit g, input logic [2:0] s,
                        input logic [31:0] a, input logic [3:0] c, input bit r,
                        input string tag);
        bit start, permit, cap, pop;
        pipe_n = !p; gnt_n = !g; st = s; ad = a; cmd = c; q_ready = r;
        pop    = r && (model.size() != 0);
        start  = g && (s == 3'b111);
        permit = m_armed || start;
        cap    = p && permit;
        if (p && !permit) m_perr = 1;
        if (pop) void'(model.pop_front());
        if (cap) begin
            if (model.size() < D) model.push_back({a, c});
            else m_ovf = 1;
        end
        m_armed = start || (m_armed && (p || !m_burst));
        m_burst = cap;
        @(posedge clk);
        @(negedge clk);
        check_ports(tag);
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        check_ports("R1");
        // R10: strobe never used, grant and status wander
        for (int i = 0; i < 32; i++) step(0, i[0], i[3:1], 32'h1000 + i, i[3:0], i[2], "R10");
        // R5/R4: non-start status codes give no permission
        do_reset();
        for (int s = 0; s < 7; s++) step(1, 1, s[2:0], 32'hBAD0 + s, 4'h3, 0, "R5");
        step(1, 0, 3'b111, 32'hBAD7, 4'h1, 0, "R4");
        // R4/R6/R2: start grant same edge, sweep every command with draining
        do_reset();
        step(1, 1, 3'b111, 32'hA000_0000, 4'h0, 0, "R4");
        for (int c = 0; c < 16; c++) step(1, 0, 3'b000, 32'h1234_0000 + c * 16, c[3:0], 1, "R6");
        step(0, 0, 3'b000, 0, 0, 1, "R3");
        step(0, 0, 3'b000, 0, 0, 1, "R3");
        // burst ended: strobe without a new grant is dropped
        step(1, 0, 3'b000, 32'hDEAD, 4'h2, 0, "R4");
        step(0, 0, 3'b000, 0, 0, 1, "R5");
        // R4: permission survives idle gap before the burst
        do_reset();
        step(0, 1, 3'b111, 0, 0, 0, "R4");
        step(0, 0, 3'b000, 0, 0, 0, "R4");
        step(0, 0, 3'b000, 0, 0, 0, "R4");
        step(1, 0, 3'b000, 32'h5555_0001, 4'hA, 0, "R4");
        step(1, 0, 3'b000, 32'h5555_0002, 4'h5, 0, "R2");
        step(0, 0, 3'b000, 0, 0, 0, "R3");
        for (int i = 0; i < 3; i++) step(0, 0, 3'b000, 0, 0, 1, "R7");
        // R8/R7: fill, overflow, drain in order
        do_reset();
        step(0, 1, 3'b111, 0, 0, 0, "R4");
        for (int i = 0; i < D + 2; i++) step(1, 0, 3'b000, 32'hC000 + i * 3, i[3:0], 0, "R8");
        step(0, 0, 3'b000, 0, 0, 0, "R7");
        for (int i = 0; i < D + 1; i++) step(0, 0, 3'b000, 0, 0, i[0], "R7");
        for (int i = 0; i < D; i++) step(0, 0, 3'b000, 0, 0, 1, "R7");
        // R9: full with pop on same edge accepts
        do_reset();
        step(0, 1, 3'b111, 0, 0, 0, "R4");
        for (int i = 0; i < D; i++) step(1, 0, 3'b000, 32'hE000 + i, 4'h9, 0, "R2");
        for (int i = 0; i < 3; i++) step(1, 0, 3'b000, 32'hF000 + i, 4'h6, 1, "R9");
        for (int i = 0; i < D + 1; i++) step(0, 0, 3'b000, 0, 0, 1, "R9");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule